// File: doc/BRIEF.md
# Automatic Recording Level Controller

This block closes a digital gain loop around a recording path. It takes a stream of signed 24-bit converter samples for two channels. For the selected channel it measures the peak magnitude over fixed windows of samples and turns that peak into a level on a 1.5 dB grid. It then moves a 6-bit amplifier gain code up or down until the measured peak sits at a programmed target. On the gain code, code 0 is -34.5 dB, code 23 is 0 dB, each code adds 1.5 dB, and every code from 45 upward gives +33 dB.

The speed of the correction follows two ramp-time codes, one for lowering gain and one for raising it, and each code step doubles the ramp time. A millisecond tick from elsewhere in the chip paces the ramp. A noise gate can either freeze the gain or raise a mute flag when the signal drops below a programmable floor. When the loop is switched off, the gain code simply follows a manually programmed value.

Top module: `alc_ctrl`

## Requirements
- R1: While reset is held, and on its release, `gain_code` is 23 and `mute` is 0.
- R2: When `chan_sel` is 00 or 11 the loop is off, and `gain_code` takes the value of `man_gain` (any 6-bit code) on the next clock.
- R3: `chan_sel` 01 measures the `smp_r` stream only and 10 measures the `smp_l` stream only.
- R4: The measured level is the largest magnitude in each run of 256 strobed samples. It is updated when the last sample of the run arrives. The level index is 4·p + f, where p is the bit position of the leading one and f is the two bits below it. Zero gives index 0. The most negative sample counts as the largest positive magnitude, which gives index 91.
- R5: The target index is 73 + `target` (index 88 is -6 dBFS). A level above the target lowers the gain. A level below it raises the gain. An equal level holds the gain.
- R6: The gain ceiling is 15 + 4·`max_gain`. If the gain is above the ceiling while the loop runs, it drops to the ceiling on the next clock. Raising the gain stops at the ceiling and lowering it stops at code 0.
- R7: Each `ms_tick` adds 40 to a ramp accumulator. One code step is taken when the accumulator reaches the ramp time in ms: 6·2^`atk_code` when lowering and 24·2^`dcy_code` when raising, with codes above 10 treated as 10. The accumulator then keeps the remainder, kept below the ramp time. There is at most one step per tick, and the gain never moves without a tick. The accumulator clears when the direction is hold or changes.
- R8: The gate floor index is 41 + `gate_thr`. The gate is active only when the loop runs, `gate_en` is 1, `gate_type` is not 11 and the level is strictly below the floor.
- R9: While the gate is active the gain is held. `mute` goes to 1 on the next clock only for `gate_type` 01, and it is 0 whenever the gate is not active in that mode.
- R10: If a lower ceiling and a ramp step fall in the same cycle, the ceiling wins and the gain lands exactly on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Strobe: a new sample pair is present |
| smp_l | input | 24 | Left sample, two's complement |
| smp_r | input | 24 | Right sample, two's complement |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| chan_sel | input | 2 | 00/11 off, 01 right, 10 left |
| max_gain | input | 3 | Gain ceiling code |
| target | input | 4 | Target level code |
| atk_code | input | 4 | Ramp time code for lowering gain |
| dcy_code | input | 4 | Ramp time code for raising gain |
| gate_thr | input | 5 | Noise floor code |
| gate_type | input | 2 | Gate action: bit0 clear hold, 01 mute, 11 none |
| gate_en | input | 1 | Gate enable |
| man_gain | input | 6 | Gain code used while the loop is off |
| gain_code | output | 6 | Current amplifier gain code |
| mute | output | 1 | Gate mute flag |

## Verification
The case of interest is a ramp step and a ceiling change that land in the same clock. The bench holds the loop in a raising state, then lowers `max_gain` in the very cycle that carries `ms_tick`. It expects the gain to land exactly on the new ceiling, not one code above or below it. The gate floor comparison is checked from both sides, with a sample whose level index sits exactly on the floor.

// File: rtl/alc_pkg.sv
package alc_pkg;

  localparam int SMP_W  = 24;
  localparam int MAG_W  = SMP_W - 1;
  localparam int LVL_W  = 7;
  localparam int GAIN_W = 6;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } dir_e;

  localparam logic [1:0] SEL_RIGHT = 2'b01;
  localparam logic [1:0] SEL_LEFT  = 2'b10;
  localparam logic [1:0] GATE_MUTE = 2'b01;
  localparam logic [1:0] GATE_RSVD = 2'b11;

  // magnitude of a two's complement sample, most negative value saturated
  function automatic logic [MAG_W-1:0] mag_of(input logic [SMP_W-1:0] s);
    logic [SMP_W-1:0] neg;
    if (!s[SMP_W-1]) return s[MAG_W-1:0];
    if (s[MAG_W-1:0] == '0) return '1;
    neg = -s;
    return neg[MAG_W-1:0];
  endfunction

  // log-like level index: 4 per octave plus two bits under the leading one
  function automatic logic [LVL_W-1:0] lvl_of(input logic [MAG_W-1:0] m);
    logic [MAG_W+1:0] ext;
    logic [LVL_W-1:0] r;
    ext = {m, 2'b00};
    r   = '0;
    for (int i = 0; i < MAG_W; i++) begin
      if (m[i]) r = LVL_W'(4 * i) + LVL_W'(ext[i+1 -: 2]);
    end
    return r;
  endfunction

endpackage

// File: rtl/alc_peak.sv
module alc_peak
  import alc_pkg::*;
#(
  parameter int WIN = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [SMP_W-1:0] smp,
  output logic [LVL_W-1:0] lvl
);

  localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);
  localparam logic [LVL_W-1:0] LVL_TOP = lvl_of('1);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic [MAG_W-1:0] max_q, max_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [MAG_W-1:0] cur, big;

  always_comb begin
    cur   = mag_of(smp);
    big   = (cur > max_q) ? cur : max_q;
    cnt_d = cnt_q;
    max_d = max_q;
    lvl_d = lvl_q;
    if (smp_vld) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        max_d = '0;
        lvl_d = lvl_of(big);
      end else begin
        cnt_d = cnt_q + CW'(1);
        max_d = big;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      max_q <= '0;
      lvl_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      max_q <= max_d;
      lvl_q <= lvl_d;
    end
  end

  assign lvl = lvl_q;

  AST_LVL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVL_TOP); // R4

  AST_LVL_ONLY_AT_WIN_END: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_vld && cnt_q == LAST) |=> $stable(lvl_q)); // R4

endmodule

// File: rtl/alc_ramp.sv
module alc_ramp
  import alc_pkg::*;
#(
  parameter int ATK_BASE_MS = 6,
  parameter int DCY_BASE_MS = 24,
  parameter int CODE_MAX    = 10,
  parameter int SPAN        = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  dir_e       dir,
  input  logic [3:0] atk_code,
  input  logic [3:0] dcy_code,
  output logic       step
);

  localparam int TOP_MS = ((ATK_BASE_MS > DCY_BASE_MS) ? ATK_BASE_MS : DCY_BASE_MS)
                          * (2 ** CODE_MAX);
  localparam int AW = $clog2(TOP_MS + SPAN) + 1;

  logic [AW-1:0] acc_q, acc_d;
  dir_e          prev_q;
  logic [3:0]    sh;
  logic [AW-1:0] ramp, sum, rem;

  always_comb begin
    if (dir == DIR_DOWN) begin
      sh   = (atk_code > 4'(CODE_MAX)) ? 4'(CODE_MAX) : atk_code;
      ramp = AW'(ATK_BASE_MS) << sh;
    end else begin
      sh   = (dcy_code > 4'(CODE_MAX)) ? 4'(CODE_MAX) : dcy_code;
      ramp = AW'(DCY_BASE_MS) << sh;
    end
    sum   = acc_q + AW'(SPAN);
    rem   = sum - ramp;
    step  = 1'b0;
    acc_d = acc_q;
    if (dir == DIR_HOLD || dir != prev_q) begin
      acc_d = '0;
    end else if (tick) begin
      if (sum >= ramp) begin
        step  = 1'b1;
        acc_d = (rem >= ramp) ? ramp - AW'(1) : rem;
      end else begin
        acc_d = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      prev_q <= DIR_HOLD;
    end else begin
      acc_q  <= acc_d;
      prev_q <= dir;
    end
  end

  AST_ACC_CLEAR_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dir == DIR_HOLD) |=> (acc_q == '0)); // R7

endmodule

// File: rtl/alc_ctrl.sv
module alc_ctrl
  import alc_pkg::*;
#(
  parameter int WIN         = 256,
  parameter int GAIN_RST    = 23,
  parameter int CAP_BASE    = 15,
  parameter int CAP_STEP    = 4,
  parameter int TGT_BASE    = 73,
  parameter int THR_BASE    = 41,
  parameter int RANGE_CODES = 45,
  parameter int ATK_BASE_MS = 6,
  parameter int DCY_BASE_MS = 24,
  parameter int CODE_MAX    = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_vld,
  input  logic [23:0] smp_l,
  input  logic [23:0] smp_r,
  input  logic        ms_tick,
  input  logic [1:0]  chan_sel,
  input  logic [2:0]  max_gain,
  input  logic [3:0]  target,
  input  logic [3:0]  atk_code,
  input  logic [3:0]  dcy_code,
  input  logic [4:0]  gate_thr,
  input  logic [1:0]  gate_type,
  input  logic        gate_en,
  input  logic [5:0]  man_gain,
  output logic [5:0]  gain_code,
  output logic        mute
);

  localparam int SPAN = (RANGE_CODES * 9) / 10;

  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic             en;
  logic [SMP_W-1:0] smp_sel;
  logic [LVL_W-1:0] pk_lvl, tgt_lvl, thr_lvl;
  logic [GAIN_W-1:0] cap;
  logic             gate_act, gate_mute;
  dir_e             dir;
  logic             step;
  logic [GAIN_W-1:0] gain_q, gain_d;
  logic             mute_q, mute_d;

  assign en      = (chan_sel == SEL_RIGHT) || (chan_sel == SEL_LEFT);
  assign smp_sel = (chan_sel == SEL_LEFT) ? smp_l : smp_r;

  alc_peak #(.WIN(WIN)) u_peak (
    .clk     (clk),
    .rst_n   (rst_ni),
    .smp_vld (smp_vld),
    .smp     (smp_sel),
    .lvl     (pk_lvl)
  );

  always_comb begin
    cap       = GAIN_W'(CAP_BASE) + GAIN_W'(CAP_STEP) * GAIN_W'(max_gain);
    tgt_lvl   = LVL_W'(TGT_BASE) + LVL_W'(target);
    thr_lvl   = LVL_W'(THR_BASE) + LVL_W'(gate_thr);
    gate_act  = en && gate_en && (gate_type != GATE_RSVD) && (pk_lvl < thr_lvl);
    gate_mute = gate_act && (gate_type == GATE_MUTE);
    if (!en || gate_act)                        dir = DIR_HOLD;
    else if (pk_lvl > tgt_lvl && gain_q != '0)  dir = DIR_DOWN;
    else if (pk_lvl < tgt_lvl && gain_q < cap)  dir = DIR_UP;
    else                                        dir = DIR_HOLD;
  end

  alc_ramp #(
    .ATK_BASE_MS (ATK_BASE_MS),
    .DCY_BASE_MS (DCY_BASE_MS),
    .CODE_MAX    (CODE_MAX),
    .SPAN        (SPAN)
  ) u_ramp (
    .clk      (clk),
    .rst_n    (rst_ni),
    .tick     (ms_tick),
    .dir      (dir),
    .atk_code (atk_code),
    .dcy_code (dcy_code),
    .step     (step)
  );

  always_comb begin
    gain_d = gain_q;
    mute_d = gate_mute;
    if (!en)                           gain_d = man_gain;
    else if (gain_q > cap)             gain_d = cap;
    else if (step && dir == DIR_UP)    gain_d = gain_q + GAIN_W'(1);
    else if (step && dir == DIR_DOWN)  gain_d = gain_q - GAIN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q <= GAIN_W'(GAIN_RST);
      mute_q <= 1'b0;
    end else begin
      gain_q <= gain_d;
      mute_q <= mute_d;
    end
  end

  assign gain_code = gain_q;
  assign mute      = mute_q;

  AST_MANUAL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_ni)
    !en |=> gain_code == $past(man_gain)); // R2

  AST_GAIN_UNDER_CAP: assert property (@(posedge clk) disable iff (!rst_ni)
    en |=> gain_code <= $past(cap)); // R6

  AST_ONE_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_ni)
    (en && gain_q <= cap) |=> (gain_q == $past(gain_q) ||
                               gain_q == $past(gain_q) + GAIN_W'(1) ||
                               gain_q + GAIN_W'(1) == $past(gain_q))); // R7

  AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_ni)
    (en && !ms_tick && gain_q <= cap) |=> $stable(gain_q)); // R7

  AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (!rst_ni)
    (en && gate_en && !gate_type[0] && pk_lvl < thr_lvl && gain_q <= cap)
      |=> $stable(gain_q)); // R9

  AST_MUTE_CAUSE: assert property (@(posedge clk) disable iff (!rst_ni)
    !(en && gate_en && gate_type == GATE_MUTE) |=> !mute); // R9

endmodule

// File: tb/tb_alc_ctrl.sv
module tb_alc_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_vld;
  logic [23:0] smp_l, smp_r;
  logic        ms_tick;
  logic [1:0]  chan_sel;
  logic [2:0]  max_gain;
  logic [3:0]  target, atk_code, dcy_code;
  logic [4:0]  gate_thr;
  logic [1:0]  gate_type;
  logic        gate_en;
  logic [5:0]  man_gain;
  logic [5:0]  gain_code;
  logic        mute;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  alc_ctrl dut (
    .clk, .rst_n, .smp_vld, .smp_l, .smp_r, .ms_tick, .chan_sel, .max_gain,
    .target, .atk_code, .dcy_code, .gate_thr, .gate_type, .gate_en,
    .man_gain, .gain_code, .mute
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) ms_tick = 1'b1;
    @(negedge clk) ms_tick = 1'b0;
    cyc(2);
  endtask

  task automatic feed(input logic [23:0] l, input logic [23:0] r);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      smp_vld = 1'b1; smp_l = l; smp_r = r;
    end
    @(negedge clk) smp_vld = 1'b0;
    cyc(2);
  endtask

  task automatic prep(input logic [5:0] g);
    chan_sel = 2'b00; man_gain = g;
    max_gain = 3'd7; target = 4'd0; atk_code = 4'd0; dcy_code = 4'd0;
    gate_en = 1'b0; gate_type = 2'b00; gate_thr = 5'd0;
    cyc(2);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cyc(3);
    chk("R1 gain in reset", gain_code, 23);
    chk("R1 mute in reset", mute, 0);
    rst_n = 1'b1; cyc(1);
    chk("R1 gain after release", gain_code, 23);
    cyc(3);
  endtask

  task automatic t_manual();
    prep(6'd37);
    chk("R2 manual sel 00", gain_code, 37);
    chan_sel = 2'b11; man_gain = 6'd63; cyc(1);
    chk("R2 manual sel 11 code 63", gain_code, 63);
    man_gain = 6'd0; cyc(1);
    chk("R2 manual code 0", gain_code, 0);
  endtask

  task automatic t_decay_right();
    prep(6'd20);
    chan_sel = 2'b01;
    feed(24'h700000, 24'd1000);   // right level 39 < 73
    tick(); chk("R3 R5 right low raises", gain_code, 21);
    tick(); chk("R7 decay code0 each tick", gain_code, 22);
    tick(); chk("R7 decay code0 third tick", gain_code, 23);
  endtask

  task automatic t_left();
    prep(6'd30);
    chan_sel = 2'b10;
    feed(24'h700000, 24'd1000);   // left level 91 > 73
    tick(); chk("R3 left high lowers", gain_code, 29);
  endtask

  task automatic t_attack();
    prep(6'd30);
    chan_sel = 2'b01; atk_code = 4'd4;   // 96 ms
    feed(24'd0, 24'h800000);             // most negative -> level 91
    tick(); chk("R7 R4 attack tick1", gain_code, 30);
    tick(); chk("R7 attack tick2", gain_code, 30);
    tick(); chk("R7 attack tick3 steps", gain_code, 29);
  endtask

  task automatic t_target();
    prep(6'd30);
    chan_sel = 2'b01; target = 4'd15;    // target 88
    feed(24'd0, 24'h400000);             // level 88
    tick(); tick(); chk("R5 R4 equal level holds", gain_code, 30);
    target = 4'd14; cyc(2);
    tick(); chk("R5 above target lowers", gain_code, 29);
  endtask

  task automatic t_cap();
    prep(6'd40);
    chan_sel = 2'b01;
    feed(24'd0, 24'd1000);
    tick(); tick(); tick(); chk("R6 reaches cap 43", gain_code, 43);
    tick(); chk("R6 stops at cap", gain_code, 43);
    max_gain = 3'd0; cyc(1);
    chk("R6 clamp to 15", gain_code, 15);
    tick(); chk("R6 stays at 15", gain_code, 15);
    prep(6'd0);
    chan_sel = 2'b01;
    feed(24'd0, 24'h7FFFFF);
    tick(); chk("R6 floor at 0", gain_code, 0);
  endtask

  task automatic t_gate();
    prep(6'd20);
    chan_sel = 2'b01;
    feed(24'd0, 24'h000500);             // level 41
    gate_en = 1'b1; gate_type = 2'b01; gate_thr = 5'd0; cyc(2);
    chk("R8 level on floor not gated", mute, 0);
    tick(); chk("R8 not gated raises", gain_code, 21);
    gate_thr = 5'd1; cyc(2);
    chk("R9 R8 mute type 01", mute, 1);
    tick(); chk("R9 mute type holds gain", gain_code, 21);
    gate_type = 2'b00; cyc(2);
    chk("R9 hold type no mute", mute, 0);
    tick(); chk("R9 hold type 00", gain_code, 21);
    gate_type = 2'b10; cyc(2);
    tick(); chk("R9 hold type 10", gain_code, 21);
    gate_type = 2'b11; cyc(2);
    tick(); chk("R9 reserved type no effect", gain_code, 22);
    chk("R9 reserved no mute", mute, 0);
    gate_type = 2'b01; gate_en = 1'b0; cyc(2);
    chk("R8 gate disabled no mute", mute, 0);
    tick(); chk("R8 gate disabled raises", gain_code, 23);
  endtask

  task automatic t_clash();
    prep(6'd40);
    chan_sel = 2'b01;
    feed(24'd0, 24'd1000);
    @(negedge clk) begin ms_tick = 1'b1; max_gain = 3'd0; end
    @(negedge clk) ms_tick = 1'b0;
    chk("R10 clamp beats step", gain_code, 15);
  endtask

  initial begin
    smp_vld = 1'b0; smp_l = '0; smp_r = '0; ms_tick = 1'b0;
    chan_sel = 2'b00; man_gain = 6'd23; max_gain = 3'd7; target = '0;
    atk_code = '0; dcy_code = '0; gate_thr = '0; gate_type = '0; gate_en = 1'b0;
    t_reset();
    t_manual();
    t_decay_right();
    t_left();
    t_attack();
    t_target();
    t_cap();
    t_gate();
    t_clash();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule